// File: doc/BRIEF.md
# Paged Memory Read Sequencer with CRC16

This block is the byte-level engine that serves read commands on a small paged memory of 128 bytes, split into four pages of 32 bytes. It sits above a transport layer that turns bus time slots into whole bytes. That layer hands over each received byte and asks for the next byte to transmit. The engine answers with the byte to send. It also drives the memory address and the page index used to look up that page's redirection byte. A separate bus-reset pulse aborts whatever transaction is in progress.

Two commands are decoded. A plain read streams memory from a start address to the last byte and ends with one checksum. An extended read goes page by page. For each page it first sends the page's redirection byte and a checksum of it. It then sends the page data and a checksum of that data alone. The first checksum of an extended read also covers the command and the address bytes.

The checksum is CRC16 with the generator x^16+x^15+x^2+1. Bytes are shifted in least significant bit first, starting from an all-zero register. The register's bitwise inverse is sent low byte first.

Top module: `page_read_seq`

## Requirements
- R1: After `rst_ni` or a `bus_reset_i` pulse, the engine waits for a command byte. Until the command and both address bytes have arrived, `tx_byte_o` is 8'hFF.
- R2: Command 8'hF0 is followed by an address low byte and then a high byte. Only bits 6:0 of the low byte set the start address; bits 6:5 of that address are the page number. After the second address byte, each `tx_req_i` consumes one memory byte and advances `mem_addr_o` by one, up to and including byte 127.
- R3: After byte 127 of a plain read come two checksum bytes, low byte first. Each is the inverse of the CRC16 taken over the command, the low address byte, the high address byte and every data byte sent. All eight bits of both address bytes enter the CRC.
- R4: Once the final checksum of a transaction has been sent, `tx_byte_o` stays 8'hFF until a bus reset.
- R5: Command 8'hA5 first returns the redirection byte of the start page. Two checksum bytes follow, covering the command, both address bytes and that redirection byte.
- R6: In an extended read, data runs from the start address to the end of its page. Two checksum bytes of only those data bytes follow, computed from a cleared generator.
- R7: Each later page of an extended read sends, in order: its redirection byte; a checksum of that byte alone from a cleared generator; its 32 data bytes; and their checksum. After page 3's checksum, the output is 8'hFF.
- R8: A bus reset aborts any transaction at any point. No checksum is produced for the aborted read, and the next command starts from a cleared checksum.
- R9: Any command byte other than 8'hF0 or 8'hA5 makes the engine return 8'hFF and ignore received bytes until a bus reset.
- R10: Bytes received once the address phase is over have no effect on the transmitted sequence.
- R11: `mem_addr_o` changes only when a byte is received or a byte is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse that aborts the current transaction |
| rx_valid_i | input | 1 | A received byte is present on rx_byte_i |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | The transport takes tx_byte_o this cycle |
| tx_byte_o | output | 8 | Byte to transmit next |
| mem_addr_o | output | 7 | Memory byte address |
| mem_rdata_i | input | 8 | Memory data at mem_addr_o, combinational |
| redir_page_o | output | 2 | Page whose redirection byte is requested |
| redir_byte_i | input | 8 | Redirection byte of redir_page_o, combinational |

## Verification
Several behaviours are checked on every cycle: address stepping and holding, the return to command wait after a bus reset, the lock into the all-ones state, and the clearing of the generator after a redirection checksum. Whether each checksum value is right, and whether the bytes come in the right order across page boundaries, can only be shown by the bench scenarios. Those scenarios compare the whole byte stream against a CRC model written independently of the design. Ignored received bytes and fresh checksums after an abort are likewise shown only through those byte streams.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam logic [7:0]  CMD_PLAIN = 8'hF0;
  localparam logic [7:0]  CMD_EXT   = 8'hA5;
  localparam logic [15:0] CRC_POLY_R = 16'hA001;  // x^16+x^15+x^2+1, reflected

  typedef enum logic [3:0] {
    S_CMD, S_ALO, S_AHI,
    S_PDATA, S_PCRC,
    S_XREDIR, S_XRCRC, S_XDATA, S_XDCRC,
    S_ONES
  } state_e;

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                             input logic [7:0]  d);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_R;
    end
    return c;
  endfunction
endpackage

// File: rtl/prs_crc16.sv
module prs_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, base;

  assign base = clr_i ? 16'h0000 : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= 16'h0000;
    else if (upd_i) crc_q <= prs_pkg::crc16_byte(base, data_i);
    else if (clr_i) crc_q <= 16'h0000;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/prs_addr.sv
module prs_addr #(
  parameter int ADDR_W = 7,
  parameter int OFF_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W:0]   addr_o,      // top bit marks past end of memory
  output logic              page_end_o,
  output logic              mem_end_o
);
  logic [ADDR_W:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= {1'b0, load_val_i};
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o     = addr_q;
  assign page_end_o = &addr_q[OFF_W-1:0];
  assign mem_end_o  = &addr_q[ADDR_W-1:0];
endmodule

// File: rtl/page_read_seq.sv
module page_read_seq #(
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 4,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(NUM_PAGES),
  localparam int ADDR_W = OFF_W + PG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              tx_req_i,
  output logic [7:0]        tx_byte_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [PG_W-1:0]   redir_page_o,
  input  logic [7:0]        redir_byte_i
);
  import prs_pkg::*;

  state_e          st_q, st_d;
  logic            crc_hi_q, crc_hi_d;
  logic            ext_q, ext_d;
  logic            crc_clr, crc_upd;
  logic [7:0]      crc_din;
  logic [15:0]     crc_q;
  logic            a_load, a_inc;
  logic [ADDR_W:0] addr_q;
  logic            page_end, mem_end;

  prs_crc16 u_crc (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (crc_clr), .upd_i (crc_upd), .data_i (crc_din),
    .crc_o (crc_q)
  );

  prs_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i (a_load), .load_val_i (rx_byte_i[ADDR_W-1:0]), .inc_i (a_inc),
    .addr_o (addr_q), .page_end_o (page_end), .mem_end_o (mem_end)
  );

  always_comb begin
    st_d     = st_q;
    crc_hi_d = crc_hi_q;
    ext_d    = ext_q;
    crc_clr  = 1'b0;
    crc_upd  = 1'b0;
    crc_din  = rx_byte_i;
    a_load   = 1'b0;
    a_inc    = 1'b0;
    if (bus_reset_i) begin
      st_d     = S_CMD;
      crc_hi_d = 1'b0;
      crc_clr  = 1'b1;
    end else begin
      unique case (st_q)
        S_CMD: if (rx_valid_i) begin
          crc_clr = 1'b1;
          crc_upd = 1'b1;
          ext_d   = (rx_byte_i == CMD_EXT);
          st_d    = (rx_byte_i == CMD_PLAIN || rx_byte_i == CMD_EXT) ? S_ALO : S_ONES;
        end
        S_ALO: if (rx_valid_i) begin
          crc_upd = 1'b1;
          a_load  = 1'b1;
          st_d    = S_AHI;
        end
        S_AHI: if (rx_valid_i) begin
          crc_upd = 1'b1;
          st_d    = ext_q ? S_XREDIR : S_PDATA;
        end
        S_PDATA: if (tx_req_i) begin
          crc_upd = 1'b1;
          crc_din = mem_rdata_i;
          a_inc   = 1'b1;
          if (mem_end) st_d = S_PCRC;
        end
        S_PCRC: if (tx_req_i) begin
          crc_hi_d = ~crc_hi_q;
          if (crc_hi_q) st_d = S_ONES;
        end
        S_XREDIR: if (tx_req_i) begin
          crc_upd = 1'b1;
          crc_din = redir_byte_i;
          st_d    = S_XRCRC;
        end
        S_XRCRC: if (tx_req_i) begin
          crc_hi_d = ~crc_hi_q;
          if (crc_hi_q) begin
            crc_clr = 1'b1;
            st_d    = S_XDATA;
          end
        end
        S_XDATA: if (tx_req_i) begin
          crc_upd = 1'b1;
          crc_din = mem_rdata_i;
          a_inc   = 1'b1;
          if (page_end) st_d = S_XDCRC;
        end
        S_XDCRC: if (tx_req_i) begin
          crc_hi_d = ~crc_hi_q;
          if (crc_hi_q) begin
            crc_clr = 1'b1;  // next redirection byte starts a fresh CRC
            st_d    = addr_q[ADDR_W] ? S_ONES : S_XREDIR;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_CMD;
      crc_hi_q <= 1'b0;
      ext_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      crc_hi_q <= crc_hi_d;
      ext_q    <= ext_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_PDATA, S_XDATA:         tx_byte_o = mem_rdata_i;
      S_XREDIR:                 tx_byte_o = redir_byte_i;
      S_PCRC, S_XRCRC, S_XDCRC: tx_byte_o = crc_hi_q ? ~crc_q[15:8] : ~crc_q[7:0];
      default:                  tx_byte_o = 8'hFF;
    endcase
  end

  assign mem_addr_o   = addr_q[ADDR_W-1:0];
  assign redir_page_o = addr_q[ADDR_W-1 -: PG_W];
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_reset_i,
  input logic              rx_valid_i,
  input logic [7:0]        rx_byte_i,
  input logic              tx_req_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input prs_pkg::state_e   st_q,
  input logic              crc_hi_q,
  input logic [15:0]       crc_q
);
  import prs_pkg::*;

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> st_q == S_CMD);

  p_ones_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_ONES && !bus_reset_i) |=> st_q == S_ONES);

  p_bad_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_CMD && rx_valid_i && !bus_reset_i &&
     rx_byte_i != CMD_PLAIN && rx_byte_i != CMD_EXT) |=> st_q == S_ONES);

  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_req_i && !rx_valid_i) |=> $stable(mem_addr_o));

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i && !bus_reset_i && (st_q == S_PDATA || st_q == S_XDATA))
    |=> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

  p_crc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_XRCRC && crc_hi_q && tx_req_i && !bus_reset_i)
    |=> (crc_q == 16'h0000 && st_q == S_XDATA));
endmodule

bind page_read_seq prs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .rx_valid_i  (rx_valid_i),
  .rx_byte_i   (rx_byte_i),
  .tx_req_i    (tx_req_i),
  .mem_addr_o  (mem_addr_o),
  .st_q        (st_q),
  .crc_hi_q    (crc_hi_q),
  .crc_q       (crc_q)
);

// File: tb/page_read_seq_tb.sv
module page_read_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_req = 1'b0;
  logic [7:0] tx_byte;
  logic [6:0] mem_addr;
  logic [7:0] mem_rdata;
  logic [1:0] redir_page;
  logic [7:0] redir_byte;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [7:0] mem_fn(input logic [6:0] a);
    return 8'({1'b0, a} * 8'd29 + 8'h3B) ^ {1'b0, a};
  endfunction

  function automatic logic [7:0] redir_fn(input logic [1:0] p);
    case (p)
      2'd1:    return 8'hFD;
      2'd2:    return 8'hFC;
      2'd3:    return 8'hFF;
      default: return 8'hFE;
    endcase
  endfunction

  function automatic logic [15:0] crc_m(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign mem_rdata  = mem_fn(mem_addr);
  assign redir_byte = redir_fn(redir_page);

  page_read_seq u_dut (
    .clk_i (clk), .rst_ni (rst_n), .bus_reset_i (bus_reset),
    .rx_valid_i (rx_valid), .rx_byte_i (rx_byte),
    .tx_req_i (tx_req), .tx_byte_o (tx_byte),
    .mem_addr_o (mem_addr), .mem_rdata_i (mem_rdata),
    .redir_page_o (redir_page), .redir_byte_i (redir_byte)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pull(output logic [7:0] b);
    @(negedge clk);
    b = tx_byte;
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic pull_chk(input string tag, input logic [7:0] exp);
    logic [7:0] b;
    pull(b);
    check(tag, {8'h00, b}, {8'h00, exp});
  endtask

  task automatic pull_crc(input string tag, input logic [15:0] c);
    logic [15:0] inv;
    inv = ~c;
    pull_chk(tag, inv[7:0]);
    pull_chk(tag, inv[15:8]);
  endtask

  task automatic do_bus_reset;
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 idle output", {8'h00, tx_byte}, 16'h00FF);
    pull_chk("R1 request while idle", 8'hFF);
    send_rx(8'hF0);
    pull_chk("R1 output before address", 8'hFF);
    do_bus_reset();
  endtask

  // plain read; inject a received byte mid-stream for R10
  task automatic t_plain(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] c;
    logic [6:0]  a;
    c = crc_m(16'h0000, 8'hF0);
    c = crc_m(c, lo);
    c = crc_m(c, hi);
    send_rx(8'hF0); send_rx(lo); send_rx(hi);
    repeat (4) @(negedge clk);
    check("R11 address held", {9'h000, mem_addr}, {9'h000, lo[6:0]});
    a = lo[6:0];
    for (int i = 0; i < 128; i++) begin
      pull_chk("R2 plain data", mem_fn(a));
      c = crc_m(c, mem_fn(a));
      if (i == 1) send_rx(8'hA5);  // R10: no effect expected
      if (a == 7'h7F) break;
      a = a + 7'd1;
    end
    pull_crc("R3 plain CRC", c);
    pull_chk("R4 ones after CRC", 8'hFF);
    pull_chk("R4 ones after CRC", 8'hFF);
    do_bus_reset();
  endtask

  task automatic t_ext(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] c;
    logic [6:0]  a;
    logic [1:0]  p;
    a = lo[6:0];
    p = a[6:5];
    send_rx(8'hA5); send_rx(lo); send_rx(hi);
    c = crc_m(crc_m(crc_m(16'h0000, 8'hA5), lo), hi);
    pull_chk("R5 first redirection byte", redir_fn(p));
    c = crc_m(c, redir_fn(p));
    pull_crc("R5 redirection CRC", c);
    for (int pg = int'(p); pg < 4; pg++) begin
      if (pg != int'(p)) begin
        pull_chk("R7 next redirection byte", redir_fn(2'(pg)));
        pull_crc("R7 redirection-only CRC", crc_m(16'h0000, redir_fn(2'(pg))));
      end
      c = 16'h0000;
      for (int i = 0; i < 32; i++) begin
        pull_chk("R6 page data", mem_fn(a));
        c = crc_m(c, mem_fn(a));
        a = a + 7'd1;
        if (a[4:0] == 5'd0) break;
      end
      pull_crc("R6 page CRC", c);
    end
    pull_chk("R7 ones after last page", 8'hFF);
    pull_chk("R7 ones after last page", 8'hFF);
    do_bus_reset();
  endtask

  task automatic t_abort;
    logic [7:0] b;
    send_rx(8'hF0); send_rx(8'h10); send_rx(8'h00);
    pull(b); pull(b); pull(b);
    do_bus_reset();
    @(negedge clk);
    check("R8 output after abort", {8'h00, tx_byte}, 16'h00FF);
    t_ext(8'h60, 8'h00);  // fresh CRC proven by full stream
  endtask

  task automatic t_unknown;
    send_rx(8'h33);
    pull_chk("R9 unknown command", 8'hFF);
    send_rx(8'hF0); send_rx(8'h00); send_rx(8'h00);
    pull_chk("R9 bytes ignored", 8'hFF);
    pull_chk("R9 bytes ignored", 8'hFF);
    do_bus_reset();
    t_plain(8'h7C, 8'h00);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain(8'h70, 8'h00);
    t_plain(8'hFF, 8'h01);   // bit 7 and high byte only enter the CRC
    t_ext(8'h5C, 8'h00);
    t_ext(8'h05, 8'h00);
    t_abort();
    t_unknown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule